// File: doc/BRIEF.md
# Sprite Attribute RAM Sweep Sequencer

This block shares one sprite attribute RAM between a CPU bus and a per-scanline sweep engine. The horizontal phase bits decide who owns the address. With the 2H phase low, the CPU address goes straight through to the RAM. With 2H high, the sequencer drives the address itself, and the three upper RAM address bits are forced high. That confines the sweep to the top 128 words of the RAM.

Each rising edge of the active-low horizontal sync restarts the sweep at sprite 0. The RAM holds 64 sprites as word pairs: the even word carries the vertical attributes and the odd word the horizontal ones. Sprites that an external comparator does not flag are skipped at one step each. On a flagged sprite the sequencer does three things in turn:

- It strobes the even word into the downstream vertical latch.
- It selects the odd word and strobes it into the horizontal latch.
- It raises a load enable while a pixel-group counter runs through 4 groups for a small sprite or 8 groups for a large one.

The sweep stops after sprite 63 or once the line's step budget is spent. Because of this, lower-numbered sprites win when a line is crowded.

Top module: `sprite_sweep_seq`

## Requirements
- R1: While `h2` is 0, `ram_addr` equals `cpu_addr` and `ram_addr_hi` equals `cpu_addr_hi` in the same cycle.
- R2: While `h2` is 1, `ram_addr_hi` is all ones and `ram_addr` is `{sprite_index[5:0], word}`, where word 0 is the vertical word and word 1 the horizontal word.
- R3: The clock edge that first sees `hsync_n` high after a low restarts the sweep at sprite 0. In the next cycle `ld_en` is 0 and `grp` is 0, even if a sprite was streaming.
- R4: Sprites are visited in ascending index order. A sprite whose `match_n` is 1 on its `h2`-high step costs exactly one step, so with no matches the `h2`-high addresses after a restart are 0, 2, 4, … 126.
- R5: A sprite with `match_n` 0 on its step gives `vset_n` low for exactly one `h2`-high cycle with its even address. The next `h2`-high cycle gives `hset_n` low with the odd address of the same sprite. The two strobes are never low together.
- R6: With `size_big` 0 when the match is taken, `grp` runs 0,1,2,3 (4 groups) and `grp[2]` (the H16 bit) stays 0. `grp[0]` is H4 and `grp[1]` is H8.
- R7: With `size_big` 1 when the match is taken, `grp` runs 0 through 7 (8 groups) before the next sprite is visited.
- R8: `grp` steps only on the clock edge that samples `{h2,h1}` = 11, so a new value first appears in the phase-00 cycle.
- R9: `ld_en` is 1 only while a matched sprite's groups are streaming. It is never 1 together with a low strobe, and it is 0 out of reset.
- R10: After reset, after sprite 63 has been handled, or after 192 `h2`-high steps since the restart, the block stays idle until the next restart. In the idle state there are no strobes and `ld_en` is 0, whatever `match_n` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h1 | input | 1 | Horizontal position bit 0 |
| h2 | input | 1 | Horizontal position bit 1; high selects the sweep |
| hsync_n | input | 1 | Active-low horizontal sync; rising edge restarts |
| cpu_addr | input | 7 | CPU low address bits |
| cpu_addr_hi | input | 3 | CPU upper address bits |
| match_n | input | 1 | Active-low comparator hit for the addressed sprite |
| size_big | input | 1 | Size bit of the addressed sprite (1 = 8 groups) |
| ram_addr | output | 7 | RAM low address bits |
| ram_addr_hi | output | 3 | RAM upper address bits |
| vset_n | output | 1 | Active-low vertical word load strobe |
| hset_n | output | 1 | Active-low horizontal word load strobe |
| ld_en | output | 1 | Pixel streaming enable |
| grp | output | 3 | Pixel group counter {H16,H8,H4} |

## Verification
The restart and the streaming of a matched sprite can land in the same cycle, because a crowded line is still streaming when the next sync rises. The bench provokes this by flagging every sprite as large across two lines. It then judges the first cycle after the rise, where `ld_en` and `grp` must be zero, and it requires that the first vertical strobe of the new line names sprite 0. Within every cycle the CPU pass-through and the sweep also alternate by phase; the bench compares the address on each low-`h2` cycle against the CPU bus while sprites are being loaded.

// File: rtl/sss_pkg.sv
package sss_pkg;
   typedef enum logic [2:0] {
      SW_IDLE,
      SW_SCAN,
      SW_VCAP,
      SW_HCAP,
      SW_PIX
   } sweep_state_e;
endpackage

// File: rtl/sss_addr_arb.sv
module sss_addr_arb #(
   parameter int LO_W     = 7,
   parameter int HI_W     = 3,
   parameter bit FORCE_HI = 1'b1
) (
   input  logic            h2,
   input  logic [LO_W-1:0] cpu_lo,
   input  logic [HI_W-1:0] cpu_hi,
   input  logic [LO_W-1:0] sweep_lo,
   output logic [LO_W-1:0] ram_lo,
   output logic [HI_W-1:0] ram_hi
);
   if (LO_W < 2) begin : g_bad_lo
      $error("sss_addr_arb: LO_W must be at least 2");
   end

   assign ram_lo = h2 ? sweep_lo : cpu_lo;

   // The sweep window sits in the top of the RAM, or follows the CPU bus
   if (FORCE_HI) begin : g_force_hi
      assign ram_hi = h2 ? {HI_W{1'b1}} : cpu_hi;
   end else begin : g_pass_hi
      assign ram_hi = cpu_hi;
   end
endmodule

// File: rtl/sss_line_budget.sv
module sss_line_budget #(
   parameter int LINE_STEPS = 192
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync_n,
   input  logic step,
   output logic hs_rise,
   output logic exhausted
);
   localparam int CNT_W = (LINE_STEPS > 0) ? $clog2(LINE_STEPS + 1) : 1;

   logic hs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hs_q <= 1'b1;
      else        hs_q <= hsync_n;
   end

   assign hs_rise = hsync_n & ~hs_q;

   if (LINE_STEPS > 0) begin : g_limited
      localparam logic [CNT_W-1:0] CAP = CNT_W'(LINE_STEPS);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  cnt <= CAP;
         else if (hs_rise)            cnt <= '0;
         else if (step && cnt != CAP) cnt <= cnt + 1'b1;
      end

      assign exhausted = (cnt == CAP);

      // R10: the step count never passes the per-line budget
      p_budget_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= CAP);
   end else begin : g_unlimited
      logic unused_step;
      assign unused_step = step;
      assign exhausted   = 1'b0;
   end
endmodule

// File: rtl/sss_grp_ctr.sv
module sss_grp_ctr #(
   parameter int GRP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             advance,
   input  logic             size_big,
   output logic [GRP_W-1:0] grp,
   output logic             last
);
   if (GRP_W < 2) begin : g_bad_w
      $error("sss_grp_ctr: GRP_W must be at least 2");
   end

   localparam logic [GRP_W-1:0] BIG_LAST   = {GRP_W{1'b1}};
   localparam logic [GRP_W-1:0] SMALL_LAST = {1'b0, {(GRP_W-1){1'b1}}};

   assign last = size_big ? (grp == BIG_LAST) : (grp == SMALL_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       grp <= '0;
      else if (clear)   grp <= '0;
      else if (advance) grp <= last ? '0 : grp + 1'b1;
   end

   // R6: a small sprite never reaches the top group bit
   p_small_no_h16_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !size_big |-> !grp[GRP_W-1]);

   // R7: a large sprite wraps only after its final group
   p_big_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && size_big && grp == BIG_LAST) |=> grp == '0);
endmodule

// File: rtl/sprite_sweep_seq.sv
module sprite_sweep_seq
   import sss_pkg::*;
#(
   parameter int IDX_W         = 6,
   parameter int HI_W          = 3,
   parameter int GRP_W         = 3,
   parameter int LINE_STEPS    = 192,
   parameter bit SWEEP_HI_ONES = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               h1,
   input  logic               h2,
   input  logic               hsync_n,
   input  logic [IDX_W:0]     cpu_addr,
   input  logic [HI_W-1:0]    cpu_addr_hi,
   input  logic               match_n,
   input  logic               size_big,
   output logic [IDX_W:0]     ram_addr,
   output logic [HI_W-1:0]    ram_addr_hi,
   output logic               vset_n,
   output logic               hset_n,
   output logic               ld_en,
   output logic [GRP_W-1:0]   grp
);
   localparam int               LO_W     = IDX_W + 1;
   localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

   if (IDX_W < 1) begin : g_bad_idx
      $error("sprite_sweep_seq: IDX_W must be at least 1");
   end

   sweep_state_e     state;
   logic [IDX_W-1:0] idx;
   logic             size_q;
   logic             hs_rise;
   logic             exhausted;
   logic             grp_last;
   logic             grp_adv;
   logic             grp_clr;
   logic [GRP_W-1:0] grp_cnt;
   logic             odd_word;
   logic [LO_W-1:0]  sweep_lo;

   sss_line_budget #(.LINE_STEPS(LINE_STEPS)) u_budget (
      .clk       (clk),
      .rst_n     (rst_n),
      .hsync_n   (hsync_n),
      .step      (h2),
      .hs_rise   (hs_rise),
      .exhausted (exhausted)
   );

   // Sweep controller: one step per h2-high clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SW_IDLE;
         idx    <= '0;
         size_q <= 1'b0;
      end else if (hs_rise) begin
         state <= SW_SCAN;
         idx   <= '0;
      end else if (h2) begin
         if (exhausted) begin
            state <= SW_IDLE;
         end else begin
            case (state)
               SW_SCAN: begin
                  if (!match_n) begin
                     state  <= SW_VCAP;
                     size_q <= size_big;
                  end else if (idx == LAST_IDX) begin
                     state <= SW_IDLE;
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
               SW_VCAP: state <= SW_HCAP;
               SW_HCAP: state <= SW_PIX;
               SW_PIX: begin
                  if (h1 && grp_last) begin
                     if (idx == LAST_IDX) begin
                        state <= SW_IDLE;
                     end else begin
                        state <= SW_SCAN;
                        idx   <= idx + 1'b1;
                     end
                  end
               end
               default: state <= SW_IDLE;
            endcase
         end
      end
   end

   assign grp_adv = h2 & h1 & (state == SW_PIX) & ~exhausted;
   assign grp_clr = hs_rise | (state != SW_PIX);

   sss_grp_ctr #(.GRP_W(GRP_W)) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (grp_clr),
      .advance  (grp_adv),
      .size_big (size_q),
      .grp      (grp_cnt),
      .last     (grp_last)
   );

   assign odd_word = (state == SW_HCAP) || (state == SW_PIX);
   assign sweep_lo = {idx, odd_word};

   sss_addr_arb #(.LO_W(LO_W), .HI_W(HI_W), .FORCE_HI(SWEEP_HI_ONES)) u_arb (
      .h2       (h2),
      .cpu_lo   (cpu_addr),
      .cpu_hi   (cpu_addr_hi),
      .sweep_lo (sweep_lo),
      .ram_lo   (ram_addr),
      .ram_hi   (ram_addr_hi)
   );

   assign vset_n = ~((state == SW_VCAP) & h2 & ~exhausted);
   assign hset_n = ~((state == SW_HCAP) & h2 & ~exhausted);
   assign ld_en  = (state == SW_PIX);
   assign grp    = ld_en ? grp_cnt : '0;

   // R1: the CPU owns the whole address while h2 is low
   p_cpu_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !h2 |-> (ram_addr == cpu_addr && ram_addr_hi == cpu_addr_hi));

   // R3: a sync rise lands on sprite 0 with streaming stopped
   p_hsync_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hs_rise |=> (state == SW_SCAN && idx == '0 && !ld_en && grp == '0));

   // R5: the vertical strobe sits on an even word, the horizontal on an odd one
   p_vset_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !vset_n |-> (!ram_addr[0] && ram_addr_hi == {HI_W{1'b1}}));
   p_hset_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !hset_n |-> (ram_addr[0] && vset_n));

   // R8: a new nonzero group appears only after a phase-11 edge
   p_grp_roll_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (grp != $past(grp) && grp != '0) |-> $past(h2 && h1));

   // R9: streaming never overlaps a load strobe
   p_ld_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |-> (vset_n && hset_n));

   // R10: the idle state is silent
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SW_IDLE) |-> (vset_n && hset_n && !ld_en && grp == '0));
endmodule

// File: tb/sim_sprite_sweep_seq.sv
`timescale 1ns/1ps
module sim_sprite_sweep_seq;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       h1, h2, hsync_n;
   logic [6:0] cpu_addr;
   logic [2:0] cpu_addr_hi;
   logic       match_n, size_big;
   logic [6:0] ram_addr;
   logic [2:0] ram_addr_hi;
   logic       vset_n, hset_n, ld_en;
   logic [2:0] grp;

   logic [63:0] hit = '0;
   logic [63:0] big = '0;
   int  hpos = 0;
   bit  hs_en = 1'b1;
   int  n_chk = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   sprite_sweep_seq u0 (
      .clk(clk), .rst_n(rst_n), .h1(h1), .h2(h2), .hsync_n(hsync_n),
      .cpu_addr(cpu_addr), .cpu_addr_hi(cpu_addr_hi),
      .match_n(match_n), .size_big(size_big),
      .ram_addr(ram_addr), .ram_addr_hi(ram_addr_hi),
      .vset_n(vset_n), .hset_n(hset_n), .ld_en(ld_en), .grp(grp)
   );

   // Model of the RAM plus comparator: hit flag and size of the addressed sprite
   assign match_n  = !(ram_addr_hi == 3'b111 && !ram_addr[0] && hit[ram_addr[6:1]]);
   assign size_big = big[ram_addr[6:1]];

   // Horizontal position and CPU bus, driven just after each edge
   task automatic drive_pos();
      h1          = hpos[0];
      h2          = hpos[1];
      hsync_n     = !(hs_en && hpos < 16);
      cpu_addr    = 7'(hpos) ^ 7'h2a;
      cpu_addr_hi = 3'(hpos >> 2);
   endtask

   initial begin
      drive_pos();
      forever begin
         @(posedge clk);
         #1;
         hpos = (hpos + 1) % 384;
         drive_pos();
      end
   end

   // Monitor state
   bit         rec = 1'b0, clr_req = 1'b0, qwin = 1'b0;
   logic [6:0] scan_addr [0:79];
   int         sa_n, vcnt, hcnt, hs_bad, pass_bad, hi_bad, ld_bad, quiet_bad;
   int         roll_bad, grp_bad, scnt;
   int         vidx  [0:63];
   int         gsteps[0:63];
   int         gmax  [0:63];
   bit         gh16  [0:63];
   bit         prev_v, ld_prev;
   logic [2:0] grp_prev;
   int         lastv;

   always @(negedge clk) begin
      if (clr_req) begin
         clr_req = 1'b0;
         sa_n = 0; vcnt = 0; hcnt = 0; hs_bad = 0; pass_bad = 0; hi_bad = 0;
         ld_bad = 0; quiet_bad = 0; roll_bad = 0; grp_bad = 0; scnt = 0;
         prev_v = 1'b0; ld_prev = 1'b0; grp_prev = '0; lastv = -1;
      end else if (rec) begin
         if (h2 && sa_n < 80) begin scan_addr[sa_n] = ram_addr; sa_n++; end
         if (!h2 && (ram_addr != cpu_addr || ram_addr_hi != cpu_addr_hi)) pass_bad++;
         if (h2 && ram_addr_hi != 3'b111) hi_bad++;
         if (!vset_n) begin
            if (!h2 || ram_addr[0]) hs_bad++;
            if (vcnt < 64) vidx[vcnt] = int'(ram_addr[6:1]);
            lastv = int'(ram_addr[6:1]);
            vcnt++;
         end
         if (!hset_n) begin
            hcnt++;
            if (!h2 || !prev_v || ram_addr != {6'(lastv), 1'b1}) hs_bad++;
         end
         if (!vset_n && !hset_n) hs_bad++;
         if (h2) prev_v = !vset_n;
         if (ld_en && (!vset_n || !hset_n)) ld_bad++;
         if (qwin && (!vset_n || !hset_n || ld_en)) quiet_bad++;
         if (ld_en && !ld_prev) begin
            if (scnt < 64) begin gsteps[scnt] = 1; gmax[scnt] = int'(grp); gh16[scnt] = grp[2]; end
            if (grp != 3'd0) grp_bad++;
            scnt++;
         end else if (ld_en && ld_prev && grp != grp_prev) begin
            if (grp != grp_prev + 3'd1) grp_bad++;
            if (hpos[1:0] != 2'b00) roll_bad++;
            if (scnt > 0 && scnt <= 64) begin
               gsteps[scnt-1]++;
               if (int'(grp) > gmax[scnt-1]) gmax[scnt-1] = int'(grp);
               if (grp[2]) gh16[scnt-1] = 1'b1;
            end
         end
         ld_prev  = ld_en;
         grp_prev = grp;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input string what, input int act,
                          input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
      end
   endtask

   task automatic wait_hpos(input int v);
      do @(negedge clk); while (hpos != v);
   endtask

   task automatic start_rec(input logic [63:0] h, input logic [63:0] b);
      hit = h; big = b; clr_req = 1'b1; rec = 1'b1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9",  "ld_en in reset", int'(ld_en), 0);
      chk("R10", "vset_n in reset", int'(vset_n), 1);
      chk("R10", "hset_n in reset", int'(hset_n), 1);
      chk("R6",  "grp in reset", int'(grp), 0);
      wait_hpos(20);
      rst_n = 1'b1;
      // Idle out of reset: matches everywhere but no sync rise yet
      start_rec('1, '0);
      wait_hpos(300);
      rec = 1'b0;
      chk("R10", "strobes before first sync", vcnt + hcnt, 0);
      chk("R1",  "cpu pass-through mismatches", pass_bad, 0);
   endtask

   task automatic t_no_hits();
      int mm = 0;
      wait_hpos(16);
      start_rec('0, '0);
      wait_hpos(15);
      rec = 1'b0;
      for (int k = 0; k < 64; k++) if (scan_addr[k] != 7'(2 * k)) mm++;
      chk("R4",  "ascending sweep address mismatches", mm, 0);
      chk("R10", "address held after sprite 63", int'(scan_addr[70]), 126);
      chk("R4",  "strobes with no match", vcnt + hcnt, 0);
      chk("R1",  "cpu pass-through mismatches", pass_bad, 0);
      chk("R2",  "upper bits not forced high", hi_bad, 0);
   endtask

   task automatic t_three_hits();
      logic [63:0] h = '0;
      logic [63:0] b = '0;
      h[5] = 1'b1; h[20] = 1'b1; h[40] = 1'b1; b[20] = 1'b1;
      wait_hpos(16);
      start_rec(h, b);
      wait_hpos(15);
      rec = 1'b0;
      chk("R5", "vertical strobe count", vcnt, 3);
      chk("R5", "horizontal strobe count", hcnt, 3);
      chk("R4", "first sprite loaded", vidx[0], 5);
      chk("R4", "second sprite loaded", vidx[1], 20);
      chk("R4", "third sprite loaded", vidx[2], 40);
      chk("R5", "strobe pairing errors", hs_bad, 0);
      chk("R9", "streamed sprite count", scnt, 3);
      chk("R6", "small sprite group count", gsteps[0], 4);
      chk("R6", "small sprite last group", gmax[0], 3);
      chk("R6", "small sprite H16 seen", int'(gh16[0]) + int'(gh16[2]), 0);
      chk("R7", "large sprite group count", gsteps[1], 8);
      chk("R7", "large sprite last group", gmax[1], 7);
      chk("R6", "second small sprite group count", gsteps[2], 4);
      chk("R8", "group steps off the 11->00 edge", roll_bad, 0);
      chk("R8", "group sequence errors", grp_bad, 0);
      chk("R9", "ld_en overlapping a strobe", ld_bad, 0);
      chk("R1", "cpu pass-through while loading", pass_bad, 0);
   endtask

   task automatic t_last_only();
      logic [63:0] h = '0;
      h[63] = 1'b1;
      wait_hpos(16);
      start_rec(h, '0);
      wait_hpos(15);
      rec = 1'b0;
      chk("R10", "loads with only sprite 63 flagged", vcnt, 1);
      chk("R10", "sprite loaded", vidx[0], 63);
      chk("R6",  "sprite 63 group count", gsteps[0], 4);
   endtask

   task automatic t_budget();
      wait_hpos(16);
      start_rec('1, '1);
      hs_en = 1'b0;
      wait_hpos(15);
      wait_hpos(100);
      qwin = 1'b1;
      wait_hpos(383);
      qwin = 1'b0;
      rec = 1'b0;
      hs_en = 1'b1;
      chk_rng("R10", "sprites loaded within budget", vcnt, 5, 12);
      chk("R10", "activity after budget spent", quiet_bad, 0);
      chk("R4",  "lowest index loaded first", vidx[0], 0);
   endtask

   task automatic t_restart();
      wait_hpos(16);
      hit = '1; big = '1;
      wait_hpos(16);
      start_rec('1, '1);
      wait_hpos(17);
      chk("R3", "ld_en after sync rise", int'(ld_en), 0);
      chk("R3", "grp after sync rise", int'(grp), 0);
      wait_hpos(80);
      rec = 1'b0;
      chk_rng("R3", "loads after restart", vcnt, 1, 64);
      chk("R3", "first sprite after restart", vidx[0], 0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      t_reset();
      t_no_hits();
      t_three_hits();
      t_last_only();
      t_budget();
      t_restart();
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(100000 * 5);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule